// File: doc/BRIEF.md
# Converter Serial Result Readout Port

This block is the digital output side of a sampling converter that acts as a serial slave. A one-cycle convert-start request on the system clock begins a conversion. The block then holds its busy output high for a fixed number of system clocks. When busy drops, the 16-bit word on the sample input is stored as the new result. A host reads results over a three-wire serial link. It drives a serial clock and two active-low qualifiers, chip-select and read, and receives the word on the serial data output, most significant bit first.

The serial inputs are asynchronous to the system clock. Each one passes through a two-flop synchronizer, and its edges are detected in the system clock domain. For this reason the serial clock must be several times slower than the system clock.

The block has two read modes:
- **Read-after-conversion.** The host reads once busy has dropped and receives the fresh result. A chain input lets the port pass on the words of further converters that follow the local word, so several converters can be cascaded.
- **Read-during-conversion.** The host reads while busy is high and receives the result of the previous conversion. If a read is left unfinished when the conversion ends, a one-cycle error pulse is raised.

Top module: `ser_result_port`

## Requirements
- R1: While reset is asserted and after its release, busy_o, sdo_o and rd_err_o are all 0.
- R2: A cnvst_i pulse seen while idle raises busy_o at the next clock edge and keeps it high for exactly CONV_CYCLES system clocks. The result register takes the value of sample_i on the edge where busy_o falls, and at no other time.
- R3: A cnvst_i pulse that arrives while busy_o is high is ignored. It neither lengthens the current conversion nor starts a later one.
- R4: A word is sent MSB first over 16 serial clock pulses. sdo_o changes only after a falling edge of sclk_i, so each bit stays steady through the following rising edge.
- R5: sdo_o is 0 unless cs_n_i and rd_n_i are both low.
- R6: Each falling edge of cs_n_i reloads the shift register from the result register, so the next bit sent is the MSB again.
- R7: With mode_i = 0 (read-after-conversion), chain_i is sampled on each rising edge of sclk_i and shifted in behind the local word. The first chain bit appears on sdo_o on the pulse right after the local LSB.
- R8: With mode_i = 1 (read-during-conversion), a read made while busy_o is high returns the result held before the running conversion.
- R9: With mode_i = 1, chain_i has no effect: every bit shifted out after the local LSB is 0.
- R10: With mode_i = 1, suppose cs_n_i fell while busy_o was high and fewer than 16 falling sclk_i edges have occurred since. Then rd_err_o is high for exactly one system clock, starting on the edge where busy_o falls. A completed read, or any read with mode_i = 0, gives no pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| mode_i | input | 1 | 0 = read after conversion, 1 = read during conversion |
| cnvst_i | input | 1 | Convert-start pulse, synchronous to clk |
| sample_i | input | DATA_W | Conversion value captured when busy falls |
| sclk_i | input | 1 | Serial clock from the host |
| cs_n_i | input | 1 | Active-low chip select |
| rd_n_i | input | 1 | Active-low read enable |
| chain_i | input | 1 | Serial data from an upstream converter |
| busy_o | output | 1 | High while a conversion runs |
| sdo_o | output | 1 | Serial data output |
| rd_err_o | output | 1 | One-cycle pulse on an unfinished read-during-conversion |

## Verification
The bench reads a 24-bit frame with a known upstream pattern on the chain input. This is where an off-by-one shift point shows up, either as a duplicated local LSB or as a lost first chain bit. The same frame is read in read-during-conversion mode, and there a design that forwards the chain input emits ones after the LSB instead of zeros. Several error cases are covered: an abandoned read must give exactly one error cycle aligned to the busy fall, while a full read and an abandoned read-after-conversion must give none. A design that compares the bit count against 15, or that stretches the pulse, fails these checks. A second convert-start issued mid-conversion checks that the request is neither queued nor allowed to restart the counter. A partial read followed by a reselect checks that the MSB comes back.

// File: rtl/srp_pkg.sv
package srp_pkg;

  typedef enum logic {
    RD_AFTER  = 1'b0,
    RD_DURING = 1'b1
  } rd_mode_e;

endpackage

// File: rtl/srp_sync.sv
// Two-flop synchronizer per bit with a third stage kept for edge detection.
module srp_sync #(
  parameter int             N       = 4,
  parameter logic [N-1:0]   RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] din,
  output logic [N-1:0] dout,
  output logic [N-1:0] dprev
);

  for (genvar g = 0; g < N; g++) begin : g_bit
    logic [2:0] stage_q;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        stage_q <= {3{RST_VAL[g]}};
      end else begin
        stage_q <= {stage_q[1:0], din[g]};
      end
    end

    assign dout[g]  = stage_q[1];
    assign dprev[g] = stage_q[2];
  end

endmodule

// File: rtl/srp_conv_seq.sv
// Conversion sequencer: busy window of fixed length, result capture at its end.
module srp_conv_seq #(
  parameter int W           = 16,
  parameter int CONV_CYCLES = 400
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start_i,
  input  logic [W-1:0] sample_i,
  output logic         busy_o,
  output logic         done_o,
  output logic [W-1:0] result_o
);

  localparam int CW = $clog2(CONV_CYCLES + 1);

  logic          busy_q, busy_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          res_en;
  logic [W-1:0]  res_q;

  always_comb begin
    busy_d = busy_q;
    cnt_d  = cnt_q;
    res_en = 1'b0;
    if (!busy_q) begin
      if (start_i) begin
        busy_d = 1'b1;
        cnt_d  = CW'(CONV_CYCLES - 1);
      end
    end else if (cnt_q == '0) begin
      busy_d = 1'b0;
      res_en = 1'b1;
    end else begin
      cnt_d = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else begin
      busy_q <= busy_d;
      cnt_q  <= cnt_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_q <= '0;
    end else if (res_en) begin
      res_q <= sample_i;
    end
  end

  assign busy_o   = busy_q;
  assign done_o   = res_en;
  assign result_o = res_q;

endmodule

// File: rtl/srp_shifter.sv
// Serial shift path: reload on select, shift on sclk fall, chain capture on rise,
// read-error tracking for read-during-conversion.
module srp_shifter
  import srp_pkg::*;
#(
  parameter int W    = 16,
  parameter int CNTW = 6
) (
  input  logic         clk,
  input  logic         rst_n,
  input  rd_mode_e     mode_i,
  input  logic         load_i,
  input  logic         sel_i,
  input  logic         rise_i,
  input  logic         fall_i,
  input  logic         chain_i,
  input  logic [W-1:0] result_i,
  input  logic         busy_i,
  input  logic         done_i,
  output logic         sdo_o,
  output logic         err_o
);

  logic [W-1:0]    sh_q, sh_d;
  logic [CNTW-1:0] cnt_q, cnt_d;
  logic            chain_q, chain_d;
  logic            armed_q, armed_d;
  logic            err_q, err_d;

  always_comb begin
    sh_d    = sh_q;
    cnt_d   = cnt_q;
    chain_d = chain_q;
    armed_d = armed_q;
    err_d   = 1'b0;

    if (rise_i && sel_i) begin
      chain_d = (mode_i == RD_AFTER) ? chain_i : 1'b0;
    end

    if (load_i) begin
      sh_d    = result_i;
      cnt_d   = '0;
      chain_d = 1'b0;
      armed_d = (mode_i == RD_DURING) && busy_i && !done_i;
    end else if (fall_i && sel_i) begin
      sh_d = {sh_q[W-2:0], chain_q};
      if (cnt_q != '1) begin
        cnt_d = cnt_q + 1'b1;
      end
    end

    if (done_i) begin
      err_d   = armed_q && (cnt_d < CNTW'(W));
      armed_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q    <= '0;
      cnt_q   <= '0;
      chain_q <= 1'b0;
      armed_q <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      sh_q    <= sh_d;
      cnt_q   <= cnt_d;
      chain_q <= chain_d;
      armed_q <= armed_d;
      err_q   <= err_d;
    end
  end

  assign sdo_o = sel_i & sh_q[W-1];
  assign err_o = err_q;

endmodule

// File: rtl/ser_result_port.sv
module ser_result_port
  import srp_pkg::*;
#(
  parameter int DATA_W      = 16,
  parameter int CONV_CYCLES = 400
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mode_i,
  input  logic              cnvst_i,
  input  logic [DATA_W-1:0] sample_i,
  input  logic              sclk_i,
  input  logic              cs_n_i,
  input  logic              rd_n_i,
  input  logic              chain_i,
  output logic              busy_o,
  output logic              sdo_o,
  output logic              rd_err_o
);

  localparam int CNTW = $clog2(DATA_W) + 2;
  localparam int NSYN = 4;

  // reset: asynchronous assertion, synchronous release
  logic rst_meta_q, rst_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_q      <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_q      <= rst_meta_q;
    end
  end

  // bit order: {chain, rd_n, cs_n, sclk}
  logic [NSYN-1:0] syn_now, syn_old;
  srp_sync #(
    .N       (NSYN),
    .RST_VAL (4'b0110)
  ) u_sync (
    .clk   (clk),
    .rst_n (rst_q),
    .din   ({chain_i, rd_n_i, cs_n_i, sclk_i}),
    .dout  (syn_now),
    .dprev (syn_old)
  );

  logic sclk_rise, sclk_fall, cs_fall, sel;
  assign sclk_rise = syn_now[0] & ~syn_old[0];
  assign sclk_fall = ~syn_now[0] & syn_old[0];
  assign cs_fall   = ~syn_now[1] & syn_old[1];
  assign sel       = ~syn_now[1] & ~syn_now[2];

  logic              busy_w, done_w;
  logic [DATA_W-1:0] result_w;

  srp_conv_seq #(
    .W           (DATA_W),
    .CONV_CYCLES (CONV_CYCLES)
  ) u_seq (
    .clk      (clk),
    .rst_n    (rst_q),
    .start_i  (cnvst_i),
    .sample_i (sample_i),
    .busy_o   (busy_w),
    .done_o   (done_w),
    .result_o (result_w)
  );

  srp_shifter #(
    .W    (DATA_W),
    .CNTW (CNTW)
  ) u_shift (
    .clk      (clk),
    .rst_n    (rst_q),
    .mode_i   (rd_mode_e'(mode_i)),
    .load_i   (cs_fall),
    .sel_i    (sel),
    .rise_i   (sclk_rise),
    .fall_i   (sclk_fall),
    .chain_i  (syn_now[3]),
    .result_i (result_w),
    .busy_i   (busy_w),
    .done_i   (done_w),
    .sdo_o    (sdo_o),
    .err_o    (rd_err_o)
  );

  assign busy_o = busy_w;

endmodule

// File: rtl/srp_chk.sv
module srp_chk #(
  parameter int W = 16
) (
  input logic         clk,
  input logic         rst_n,
  input logic         cnvst_i,
  input logic         cs_n_i,
  input logic         busy_o,
  input logic         sdo_o,
  input logic         rd_err_o,
  input logic [W-1:0] result
);

  // R2
  result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$fell(busy_o) |-> $stable(result));

  // R3
  busy_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_o) |-> $past(cnvst_i));

  // R5
  desel_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_n_i && $past(cs_n_i) && $past(cs_n_i, 2)) |-> !sdo_o);

  // R10
  err_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_err_o |-> $fell(busy_o));

  // R10
  err_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_err_o |=> !rd_err_o);

endmodule

bind ser_result_port srp_chk #(.W(DATA_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .cnvst_i  (cnvst_i),
  .cs_n_i   (cs_n_i),
  .busy_o   (busy_o),
  .sdo_o    (sdo_o),
  .rd_err_o (rd_err_o),
  .result   (result_w)
);

// File: tb/test_ser_result_port.sv
`timescale 1ns/1ps
module test_ser_result_port;

  localparam int W    = 16;
  localparam int CONV = 400;
  localparam int HALF = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic mode = 1'b0, cnvst = 1'b0, sclk = 1'b0, cs_n = 1'b1, rd_n = 1'b1, chain = 1'b0;
  logic [W-1:0] sample = '0;
  logic busy, sdo, rd_err;

  int nchk = 0, nfail = 0;
  bit finished = 1'b0;
  logic [W-1:0] prev = '0;

  always #10 clk = ~clk;

  ser_result_port #(.DATA_W(W), .CONV_CYCLES(CONV)) i_ser_result_port (
    .clk(clk), .rst_n(rst_n), .mode_i(mode), .cnvst_i(cnvst), .sample_i(sample),
    .sclk_i(sclk), .cs_n_i(cs_n), .rd_n_i(rd_n), .chain_i(chain),
    .busy_o(busy), .sdo_o(sdo), .rd_err_o(rd_err)
  );

  // {mode, value}
  localparam logic [16:0] VEC [8] = '{
    {1'b0, 16'hA5C3}, {1'b0, 16'h0001}, {1'b1, 16'h8000}, {1'b0, 16'hFFFF},
    {1'b1, 16'h0000}, {1'b1, 16'h5A5A}, {1'b0, 16'h7E81}, {1'b1, 16'hC0DE}
  };

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic start_conv(input logic [W-1:0] v);
    sample = v;
    cnvst  = 1'b1;
    tick(1);
    cnvst  = 1'b0;
  endtask

  // waits for busy to drop, counting error pulse cycles
  task automatic finish_conv(input logic [W-1:0] v, output int errs);
    errs = 0;
    while (busy) begin
      tick(1);
      if (rd_err) errs++;
    end
    repeat (4) begin
      tick(1);
      if (rd_err) errs++;
    end
    prev = v;
  endtask

  task automatic select_port();
    cs_n = 1'b0; rd_n = 1'b0; tick(HALF);
  endtask

  task automatic deselect_port();
    cs_n = 1'b1; rd_n = 1'b1; tick(HALF);
  endtask

  task automatic read_bits(input int n, input logic [31:0] up, output logic [31:0] r);
    r = '0;
    for (int k = 0; k < n; k++) begin
      chain = up[31-k];
      sclk  = 1'b1;
      tick(HALF);
      r = {r[30:0], sdo};
      sclk  = 1'b0;
      tick(HALF);
    end
    chain = 1'b0;
  endtask

  initial begin
    #(20 * 150000);
    if (!finished) begin
      nchk++; nfail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  end

  initial begin
    logic [31:0] r;
    int errs, cnt;

    tick(3);
    // R1: outputs quiet in reset
    check("R1 busy", 32'(busy), 0);
    check("R1 sdo", 32'(sdo), 0);
    check("R1 rd_err", 32'(rd_err), 0);
    rst_n = 1'b1;
    tick(6);
    check("R1 busy after release", 32'(busy), 0);

    // vector table
    for (int i = 0; i < 8; i++) begin
      logic [W-1:0] v;
      logic [W-1:0] exp_v;
      v = VEC[i][15:0];
      mode = VEC[i][16];
      tick(2);
      if (!mode) begin
        start_conv(v);
        finish_conv(v, errs);
        select_port();
        read_bits(16, 32'h0, r);
        deselect_port();
        check("R4 after-mode word", r, 32'(v));
      end else begin
        exp_v = prev;
        start_conv(v);
        select_port();
        read_bits(16, 32'h0, r);
        deselect_port();
        finish_conv(v, errs);
        check("R8 during-mode previous word", r, 32'(exp_v));
        check("R10 full read no error", 32'(errs), 0);
      end
    end

    // R2 / R3: busy length, second start ignored
    mode = 1'b0;
    tick(2);
    sample = 16'h3C3C;
    cnvst = 1'b1; tick(1); cnvst = 1'b0;
    cnt = 0;
    while (busy && cnt < 2 * CONV) begin
      cnt++;
      if (cnt == 100) begin
        sample = 16'h1111;
        cnvst = 1'b1;
      end else begin
        cnvst = 1'b0;
      end
      tick(1);
    end
    cnvst = 1'b0;
    check("R2 busy length", 32'(cnt), 32'(CONV));
    tick(5);
    check("R3 no queued start", 32'(busy), 0);
    prev = 16'h1111;
    select_port();
    read_bits(16, 32'h0, r);
    deselect_port();
    check("R2 captured at busy fall", r, 32'h1111);

    // R5: qualifiers
    start_conv(16'hFFFF);
    finish_conv(16'hFFFF, errs);
    cs_n = 1'b0; rd_n = 1'b1; tick(HALF);
    check("R5 rd high", 32'(sdo), 0);
    cs_n = 1'b1; rd_n = 1'b0; tick(HALF);
    check("R5 cs high", 32'(sdo), 0);
    cs_n = 1'b0; rd_n = 1'b0; tick(HALF);
    check("R5 both low", 32'(sdo), 1);
    deselect_port();

    // R6: reload on reselect
    start_conv(16'h9ABC);
    finish_conv(16'h9ABC, errs);
    select_port();
    read_bits(4, 32'h0, r);
    check("R6 partial", r, 32'h9);
    deselect_port();
    select_port();
    read_bits(16, 32'h0, r);
    deselect_port();
    check("R6 restart at MSB", r, 32'h9ABC);

    // R7: daisy chain
    start_conv(16'h1234);
    finish_conv(16'h1234, errs);
    select_port();
    read_bits(24, 32'hC500_0000, r);
    deselect_port();
    check("R7 chain frame", r, 32'h0012_34C5);

    // R9 / R8: chain ignored in during mode
    mode = 1'b1;
    tick(2);
    start_conv(16'h4321);
    select_port();
    read_bits(24, 32'hFFFF_FFFF, r);
    deselect_port();
    finish_conv(16'h4321, errs);
    check("R9 chain ignored", r, 32'h0012_3400);
    check("R10 no error on full read", 32'(errs), 0);

    // R10: abandoned read
    start_conv(16'h0F0F);
    select_port();
    read_bits(5, 32'h0, r);
    deselect_port();
    check("R8 partial prev bits", r, 32'h08);
    errs = 0;
    while (busy) begin
      tick(1);
      if (rd_err) errs++;
    end
    check("R10 pulse at busy fall", 32'(rd_err), 1);
    repeat (4) begin
      tick(1);
      if (rd_err) errs++;
    end
    prev = 16'h0F0F;
    check("R10 one cycle pulse", 32'(errs), 1);

    // R10: no error in after mode even if read abandoned
    mode = 1'b0;
    tick(2);
    start_conv(16'h2222);
    select_port();
    read_bits(3, 32'h0, r);
    deselect_port();
    finish_conv(16'h2222, errs);
    check("R10 after-mode no error", 32'(errs), 0);

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

endmodule